// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 64K sixteen-bit words with separate upper and lower byte strobes. The host offers one word-sized request at a time with a request/ready handshake: a direction bit, an address, write data and a per-byte mask. The controller turns each request into a pin-level read or write cycle. Every pin is driven from a register, and the length of each cycle phase is a clock count.

All memory timing minimums are given as nanosecond parameters together with the clock period. At elaboration the block converts each one to a cycle count. It rounds up, and no count is less than one cycle. The data bus is modelled as separate output, per-lane output-enable and input vectors. The controller never turns its drivers on while the memory could still be driving the bus. Between requests the chip select is released, so the memory falls back to standby.

Top module: `sram_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it: chip select, write strobe, read strobe and both byte strobes are high (inactive), no lane driver is on, `host_ready` is 1 and `host_rvalid` is 0.
- R2: `host_ready` is high exactly when no memory cycle is running. Whenever it is high, chip select is high and no lane driver is on. A request is taken on a clock edge where `host_req` and `host_ready` are both high.
- R3: A read holds chip select and read strobe low with write strobe high for N_RD cycles. N_RD is the largest of the read-cycle, address-access, read-strobe-access and byte-strobe-access times, each converted to cycles. The word on `mem_dq_i` is captured at the end of the last of those cycles. On the next cycle it appears on `host_rdata` with a one-cycle `host_rvalid` pulse, and `host_ready` is high again on that same cycle. Byte lanes whose mask bit is 0 return zero.
- R4: The write strobe goes low only after chip select and the address have been applied for at least one cycle. It stays low for N_WP cycles, where N_WP = max(pulse width, strobe-to-end minus 1, address-setup-to-end minus 1, data setup), all in cycles. Chip select is low for at least the chip-select-to-write-end time before the write strobe rises.
- R5: For a write, the lane drivers are on for every cycle the write strobe is low. They are still on, with the same data, for at least one cycle after it rises.
- R6: Mask bit 0 controls byte strobe 0 and data bits 7:0. Mask bit 1 controls byte strobe 1 and bits 15:8. A lane whose mask bit is 0 keeps its strobe high, is never driven, and keeps its stored contents after the write.
- R7: The read strobe is high whenever the write strobe is low. No lane driver is on while the memory is driving that lane, which happens when chip select and read strobe are low, write strobe is high and the lane strobe is low.
- R8: After the read strobe rises, the lane drivers stay off for at least N_HZ cycles, the output-disable-to-high-impedance time in cycles. A write that follows a read waits in its setup phase until this has passed.
- R9: A request with an all-zero mask is taken without any memory cycle, and `host_ready` stays high. A zero-mask read returns `host_rvalid` on the next cycle with `host_rdata` = 0. A zero-mask write changes no stored data.
- R10: Each nanosecond value is converted as ceil(t / CLK_NS), with a minimum of 1. A write keeps chip select low for at least N_WC cycles, the write-cycle time in cycles. It does so by stretching the hold phase after the strobe to max(1, N_WC − 1 − N_WP) cycles.
- R11: The address does not change while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request valid |
| host_ready | output | 1 | Controller idle, request accepted when high together with host_req |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_mask | input | DATA_W/8 | Byte-lane mask, bit i selects bits 8i+7:8i |
| host_rdata | output | DATA_W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read-data valid pulse |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_be_n | output | DATA_W/8 | Byte strobes, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | DATA_W/8 | Per-lane driver enable |
| mem_dq_i | input | DATA_W | Data from the memory |

## Verification
A pin-level memory model in the bench stores only what the strobes actually commit. A behavioural host model predicts ready, valid and read data on every cycle. The patterns are chosen so that each exposes a different fault:
- Full-word writes followed by reads show whether data and address reach the array intact.
- Single-lane writes and reads separate the two byte lanes and show whether an unselected lane is disturbed or returned as nonzero.
- Zero-mask requests show whether a stray memory cycle or a stall occurs.
- A read followed at once by a write exercises the turnaround wait and any contention on the bus.
- Random mixes and the lowest and highest addresses cover address decoding and the timing of the phase counters against the requirement counts.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WSET = 3'd2,
      ST_WPUL = 3'd3,
      ST_WHLD = 3'd4
   } seq_state_e;

   // Round a nanosecond minimum up to whole clocks, never below one.
   function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
      int c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_bridge_seq.sv
module sram_bridge_seq
   import sram_bridge_pkg::*;
#(
   parameter int LANES = 2,
   parameter int CNT_W = 5,
   parameter int N_RD  = 18,
   parameter int N_WP  = 14,
   parameter int N_WH  = 3,
   parameter int N_HZ  = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req,
   input  logic             we,
   input  logic [LANES-1:0] mask,
   output logic             ready,
   output seq_state_e       state_q,
   output seq_state_e       state_d,
   output logic             rd_done,
   output logic             null_rd,
   output logic             hz_zero
);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] hz_q;

   assign ready   = (state_q == ST_IDLE);
   assign rd_done = (state_q == ST_RD) && (cnt_q == '0);
   assign null_rd = ready && req && !we && (mask == '0);
   assign hz_zero = (hz_q == '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      case (state_q)
         ST_IDLE: begin
            if (req && (mask != '0)) begin
               if (we) begin
                  state_d = ST_WSET;
               end else begin
                  state_d = ST_RD;
                  cnt_d   = CNT_W'(N_RD - 1);
               end
            end
         end
         ST_RD: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_WSET: begin
            if (hz_q == '0) begin
               state_d = ST_WPUL;
               cnt_d   = CNT_W'(N_WP - 1);
            end
         end
         ST_WPUL: begin
            if (cnt_q == '0) begin
               state_d = ST_WHLD;
               cnt_d   = CNT_W'(N_WH - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WHLD: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   // Turnaround guard: counts down from the moment the read strobe is released.
   always_ff @(posedge clk) begin
      if (rst)                hz_q <= '0;
      else if (rd_done)       hz_q <= CNT_W'(N_HZ);
      else if (hz_q != '0)    hz_q <= hz_q - 1'b1;
   end

   p_null_no_cycle_r9: assert property (@(posedge clk) disable iff (rst)
      (ready && req && (mask == '0)) |=> (state_q == ST_IDLE))
      else $error("zero-mask request started a memory cycle");

   p_rd_leaves_idle_r3: assert property (@(posedge clk) disable iff (rst)
      rd_done |=> (state_q == ST_IDLE))
      else $error("read did not return to idle after capture");

endmodule

// File: rtl/sram_bridge_pins.sv
module sram_bridge_pins
   import sram_bridge_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_state_e        state_d,
   input  logic [ADDR_W-1:0] sel_addr,
   input  logic [DATA_W-1:0] sel_wdata,
   input  logic [LANES-1:0]  sel_mask,
   output logic              ce_n_q,
   output logic              we_n_q,
   output logic              oe_n_q,
   output logic [LANES-1:0]  be_n_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] dq_o_q,
   output logic [LANES-1:0]  dq_oe_q
);

   logic active_d, drive_d;

   assign active_d = (state_d != ST_IDLE);
   assign drive_d  = (state_d == ST_WPUL) || (state_d == ST_WHLD);

   always_ff @(posedge clk) begin
      if (rst) begin
         ce_n_q <= 1'b1;
         we_n_q <= 1'b1;
         oe_n_q <= 1'b1;
         addr_q <= '0;
         dq_o_q <= '0;
      end else begin
         ce_n_q <= !active_d;
         we_n_q <= (state_d != ST_WPUL);
         oe_n_q <= (state_d != ST_RD);
         addr_q <= sel_addr;
         dq_o_q <= sel_wdata;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            be_n_q[l]  <= 1'b1;
            dq_oe_q[l] <= 1'b0;
         end else begin
            be_n_q[l]  <= !(active_d && sel_mask[l]);
            dq_oe_q[l] <= drive_d && sel_mask[l];
         end
      end
   end

   p_we_needs_ce_r4: assert property (@(posedge clk) disable iff (rst)
      !we_n_q |-> (!ce_n_q && oe_n_q))
      else $error("write strobe low without chip select or with read strobe low");

   p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (rst)
      (dq_oe_q != '0) |-> oe_n_q)
      else $error("lane driver on while read strobe low");

   p_addr_stable_r11: assert property (@(posedge clk) disable iff (rst)
      (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q))
      else $error("address moved while chip select low");

   p_hold_after_we_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(we_n_q) |-> ((dq_oe_q != '0) && $stable(dq_o_q)))
      else $error("write data not held after strobe release");

   p_lane_drive_masked_r6: assert property (@(posedge clk) disable iff (rst)
      ((dq_oe_q & be_n_q) == '0))
      else $error("driver on for a lane whose strobe is high");

endmodule

// File: rtl/sram_bridge_rdret.sv
module sram_bridge_rdret #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic              null_rd,
   input  logic [LANES-1:0]  mask,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   always_ff @(posedge clk) begin
      if (rst) rvalid_q <= 1'b0;
      else     rvalid_q <= cap || null_rd;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            rdata_q[8*l +: 8] <= '0;
         end else if (cap) begin
            rdata_q[8*l +: 8] <= mask[l] ? dq_i[8*l +: 8] : 8'h00;
         end else if (null_rd) begin
            rdata_q[8*l +: 8] <= 8'h00;
         end
      end
   end

   p_rvalid_source_r3: assert property (@(posedge clk) disable iff (rst)
      rvalid_q |-> $past(cap || null_rd))
      else $error("read valid without capture or zero-mask read");

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
   import sram_bridge_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int CLK_NS    = 4,
   parameter int T_RC_NS   = 70,
   parameter int T_AA_NS   = 70,
   parameter int T_DOE_NS  = 35,
   parameter int T_DBE_NS  = 35,
   parameter int T_WC_NS   = 70,
   parameter int T_PWE_NS  = 50,
   parameter int T_SCE_NS  = 60,
   parameter int T_AW_NS   = 60,
   parameter int T_SD_NS   = 30,
   parameter int T_HZOE_NS = 25
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                host_req,
   output logic                host_ready,
   input  logic                host_we,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic [DATA_W/8-1:0] host_mask,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                host_rvalid,
   output logic                mem_ce_n,
   output logic                mem_we_n,
   output logic                mem_oe_n,
   output logic [DATA_W/8-1:0] mem_be_n,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_dq_o,
   output logic [DATA_W/8-1:0] mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_i
);

   localparam int LANES = DATA_W / 8;
   localparam int C_RC  = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int C_AA  = ns_to_cyc(T_AA_NS, CLK_NS);
   localparam int C_DOE = ns_to_cyc(T_DOE_NS, CLK_NS);
   localparam int C_DBE = ns_to_cyc(T_DBE_NS, CLK_NS);
   localparam int C_WC  = ns_to_cyc(T_WC_NS, CLK_NS);
   localparam int C_PWE = ns_to_cyc(T_PWE_NS, CLK_NS);
   localparam int C_SCE = ns_to_cyc(T_SCE_NS, CLK_NS);
   localparam int C_AW  = ns_to_cyc(T_AW_NS, CLK_NS);
   localparam int C_SD  = ns_to_cyc(T_SD_NS, CLK_NS);
   localparam int N_HZ  = ns_to_cyc(T_HZOE_NS, CLK_NS);
   localparam int N_RD  = imax(imax(C_RC, C_AA), imax(C_DOE, C_DBE));
   localparam int N_WP  = imax(1, imax(imax(C_PWE, C_SD), imax(C_SCE - 1, C_AW - 1)));
   localparam int N_WH  = imax(1, C_WC - 1 - N_WP);
   localparam int CNT_MAX = imax(imax(N_RD, N_WP), imax(N_WH, N_HZ));
   localparam int CNT_W = $clog2(CNT_MAX + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a nonzero whole number of bytes");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic              accept;
   logic [ADDR_W-1:0] lat_addr, sel_addr;
   logic [DATA_W-1:0] lat_wdata, sel_wdata;
   logic [LANES-1:0]  lat_mask, sel_mask;
   seq_state_e        state_q, state_d;
   logic              rd_done, null_rd, hz_zero;

   assign accept    = host_req && host_ready;
   assign sel_addr  = accept ? host_addr  : lat_addr;
   assign sel_wdata = accept ? host_wdata : lat_wdata;
   assign sel_mask  = accept ? host_mask  : lat_mask;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_mask  <= '0;
      end else if (accept) begin
         lat_addr  <= host_addr;
         lat_wdata <= host_wdata;
         lat_mask  <= host_mask;
      end
   end

   sram_bridge_seq #(
      .LANES (LANES), .CNT_W (CNT_W), .N_RD (N_RD),
      .N_WP  (N_WP),  .N_WH  (N_WH),  .N_HZ (N_HZ)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .req     (host_req),
      .we      (host_we),
      .mask    (host_mask),
      .ready   (host_ready),
      .state_q (state_q),
      .state_d (state_d),
      .rd_done (rd_done),
      .null_rd (null_rd),
      .hz_zero (hz_zero)
   );

   sram_bridge_pins #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LANES (LANES)
   ) u_pins (
      .clk       (clk),
      .rst       (rst),
      .state_d   (state_d),
      .sel_addr  (sel_addr),
      .sel_wdata (sel_wdata),
      .sel_mask  (sel_mask),
      .ce_n_q    (mem_ce_n),
      .we_n_q    (mem_we_n),
      .oe_n_q    (mem_oe_n),
      .be_n_q    (mem_be_n),
      .addr_q    (mem_addr),
      .dq_o_q    (mem_dq_o),
      .dq_oe_q   (mem_dq_oe)
   );

   sram_bridge_rdret #(
      .DATA_W (DATA_W), .LANES (LANES)
   ) u_rdret (
      .clk      (clk),
      .rst      (rst),
      .cap      (rd_done),
      .null_rd  (null_rd),
      .mask     (lat_mask),
      .dq_i     (mem_dq_i),
      .rdata_q  (host_rdata),
      .rvalid_q (host_rvalid)
   );

   p_drive_after_turn_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_dq_oe != '0) |-> hz_zero)
      else $error("lane drivers enabled inside turnaround window");

   p_idle_standby_r2: assert property (@(posedge clk) disable iff (rst)
      host_ready |-> (mem_ce_n && (mem_dq_oe == '0)))
      else $error("chip select or drivers active while idle");

   p_seq_state_legal_r2: assert property (@(posedge clk) disable iff (rst)
      (state_q inside {ST_IDLE, ST_RD, ST_WSET, ST_WPUL, ST_WHLD}))
      else $error("illegal sequencer state");

endmodule

// File: tb/sram_bridge_tb.sv
`timescale 1ns/1ps
module sram_bridge_tb;

   function automatic int cdiv(input int t, input int c);
      int r;
      r = (t + c - 1) / c;
      return (r < 1) ? 1 : r;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int CK   = 4;
   localparam int N_RD = mx(mx(cdiv(70, CK), cdiv(70, CK)), mx(cdiv(35, CK), cdiv(35, CK)));
   localparam int N_PWE = cdiv(50, CK);
   localparam int N_SCE = cdiv(60, CK);
   localparam int N_SD  = cdiv(30, CK);
   localparam int N_WC  = cdiv(70, CK);
   localparam int N_WP  = mx(1, mx(mx(N_PWE, N_SD), mx(N_SCE - 1, cdiv(60, CK) - 1)));
   localparam int N_WH  = mx(1, N_WC - 1 - N_WP);
   localparam int N_HZ  = cdiv(25, CK);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_req = 1'b0, host_we = 1'b0;
   logic [15:0] host_addr = '0, host_wdata = '0;
   logic [1:0]  host_mask = '0;
   logic host_ready, host_rvalid;
   logic [15:0] host_rdata;
   logic mem_ce_n, mem_we_n, mem_oe_n;
   logic [1:0] mem_be_n, mem_dq_oe;
   logic [15:0] mem_addr, mem_dq_o;
   logic [15:0] mem_dq_i;

   always #2 clk = ~clk;

   sram_bridge u_dut (
      .clk (clk), .rst (rst),
      .host_req (host_req), .host_ready (host_ready), .host_we (host_we),
      .host_addr (host_addr), .host_wdata (host_wdata), .host_mask (host_mask),
      .host_rdata (host_rdata), .host_rvalid (host_rvalid),
      .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
      .mem_be_n (mem_be_n), .mem_addr (mem_addr), .mem_dq_o (mem_dq_o),
      .mem_dq_oe (mem_dq_oe), .mem_dq_i (mem_dq_i)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] init_pat(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h3C5A;
   endfunction

   // Pin-level memory model
   logic [15:0] sram_mem [logic [15:0]];
   function automatic logic [15:0] sram_word(input logic [15:0] a);
      if (sram_mem.exists(a)) return sram_mem[a];
      return init_pat(a);
   endfunction

   always @* begin
      logic [15:0] w;
      w = sram_word(mem_addr);
      for (int l = 0; l < 2; l++) begin
         if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
            mem_dq_i[8*l +: 8] = w[8*l +: 8];
         else
            mem_dq_i[8*l +: 8] = 8'h5A;
      end
   end

   // Host-side reference model
   logic [15:0] mdl_mem [logic [15:0]];
   function automatic logic [15:0] mdl_word(input logic [15:0] a);
      if (mdl_mem.exists(a)) return mdl_mem[a];
      return init_pat(a);
   endfunction

   int m_busy = 0, m_hz = 0;
   bit m_pend_rd = 0;
   logic [15:0] m_pend = '0;
   bit exp_rvalid = 0;
   logic [15:0] exp_rdata = '0;

   always @(posedge clk) begin
      int h_pre;
      if (rst) begin
         m_busy = 0; m_hz = 0; m_pend_rd = 0; exp_rvalid = 0;
      end else begin
         h_pre = m_hz;
         exp_rvalid = 0;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0 && m_pend_rd) begin
               exp_rvalid = 1; exp_rdata = m_pend; m_pend_rd = 0; m_hz = N_HZ;
            end else if (m_hz > 0) m_hz--;
         end else begin
            if (m_hz > 0) m_hz--;
            if (host_req) begin
               if (host_mask == 2'b00) begin
                  if (!host_we) begin exp_rvalid = 1; exp_rdata = 16'h0000; end
               end else if (!host_we) begin
                  logic [15:0] w;
                  w = mdl_word(host_addr);
                  m_pend = {host_mask[1] ? w[15:8] : 8'h00, host_mask[0] ? w[7:0] : 8'h00};
                  m_pend_rd = 1;
                  m_busy = N_RD;
               end else begin
                  logic [15:0] w;
                  w = mdl_word(host_addr);
                  if (host_mask[0]) w[7:0]  = host_wdata[7:0];
                  if (host_mask[1]) w[15:8] = host_wdata[15:8];
                  mdl_mem[host_addr] = w;
                  m_busy = mx(1, h_pre) + N_WP + N_WH;
               end
            end
         end
      end
   end

   // Per-cycle monitor
   logic prev_ce_n = 1, prev_we_n = 1;
   logic [15:0] prev_addr = '0;
   int ce_lo = 0, we_lo = 0, drv_lo = 0, oe_hi = 1000;
   bit had_wr = 0;

   always @(negedge clk) begin
      if (!rst) begin
         chk(host_ready == (m_busy == 0), "R2 ready", host_ready, (m_busy == 0));
         chk(host_rvalid == exp_rvalid, "R3/R9 rvalid", host_rvalid, exp_rvalid);
         if (exp_rvalid) chk(host_rdata == exp_rdata, "R3/R6/R9 rdata", host_rdata, exp_rdata);
         if (host_ready) chk(mem_ce_n && mem_dq_oe == 2'b00, "R2 standby when idle",
                             {mem_ce_n, mem_dq_oe}, 3'b100);
         if (!mem_we_n) chk(mem_oe_n, "R7 read strobe high in write", mem_oe_n, 1);
         for (int l = 0; l < 2; l++)
            if (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
               chk(!mem_dq_oe[l], "R7 contention", mem_dq_oe[l], 0);
         if (mem_dq_oe != 2'b00) chk(oe_hi > N_HZ, "R8 turnaround", oe_hi, N_HZ + 1);
         if (mem_dq_oe & mem_be_n) chk(0, "R6 driver on masked lane", mem_dq_oe, ~mem_be_n);
         if (!mem_ce_n && !prev_ce_n) chk(mem_addr == prev_addr, "R11 address stable", mem_addr, prev_addr);
         if (prev_we_n && !mem_we_n) chk(ce_lo >= 1, "R4 address before strobe", ce_lo, 1);
         if (!prev_we_n && mem_we_n) begin
            logic [15:0] w;
            chk(we_lo >= N_PWE, "R4 strobe width", we_lo, N_PWE);
            chk(ce_lo >= N_SCE, "R4 select to write end", ce_lo, N_SCE);
            chk(drv_lo >= N_SD, "R5 data setup", drv_lo, N_SD);
            w = sram_word(mem_addr);
            for (int l = 0; l < 2; l++) begin
               if (!mem_be_n[l]) begin
                  chk(mem_dq_oe[l], "R5 data hold", mem_dq_oe[l], 1);
                  w[8*l +: 8] = mem_dq_o[8*l +: 8];
               end
            end
            sram_mem[mem_addr] = w;
         end
         if (!prev_ce_n && mem_ce_n)
            chk(ce_lo >= (had_wr ? N_WC : N_RD), "R10 cycle length", ce_lo, had_wr ? N_WC : N_RD);
      end
      // counters
      if (mem_ce_n) begin ce_lo = 0; had_wr = 0; end else ce_lo++;
      if (mem_we_n) begin we_lo = 0; drv_lo = 0; end
      else begin
         we_lo++; had_wr = 1;
         if ((mem_dq_oe | mem_be_n) == 2'b11) drv_lo++;
      end
      if (!mem_oe_n) oe_hi = 0; else if (oe_hi < 1000) oe_hi++;
      prev_ce_n = mem_ce_n; prev_we_n = mem_we_n; prev_addr = mem_addr;
   end

   task automatic issue(input bit we, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
      while (!host_ready) @(negedge clk);
      host_req = 1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
      @(negedge clk);
      host_req = 0;
   endtask

   task automatic drain();
      while (!host_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state while reset held
      chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, "R1 strobes in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
      chk(mem_dq_oe == 2'b00, "R1 drivers in reset", mem_dq_oe, 0);
      chk(host_ready && !host_rvalid, "R1 host side in reset", {host_ready, host_rvalid}, 2'b10);
      rst = 0;
      @(negedge clk);
      chk(mem_ce_n && mem_dq_oe == 2'b00 && host_ready, "R1 after reset",
          {mem_ce_n, mem_dq_oe, host_ready}, 4'b1001);

      // read untouched words, both lanes
      issue(0, 16'h0000, 0, 2'b11);
      issue(0, 16'hFFFF, 0, 2'b11);
      // full-word writes and read back, address extremes
      issue(1, 16'h0000, 16'hBEEF, 2'b11);
      issue(1, 16'hFFFF, 16'h1234, 2'b11);
      issue(0, 16'h0000, 0, 2'b11);
      issue(0, 16'hFFFF, 0, 2'b11);
      // single-lane writes (R6)
      issue(1, 16'h0100, 16'hAA55, 2'b01);
      issue(0, 16'h0100, 0, 2'b11);
      issue(1, 16'h0100, 16'hC3C3, 2'b10);
      issue(0, 16'h0100, 0, 2'b11);
      // single-lane reads return zero in the other lane (R3)
      issue(0, 16'h0100, 0, 2'b01);
      issue(0, 16'h0100, 0, 2'b10);
      // zero-mask requests (R9)
      issue(1, 16'h0100, 16'hFFFF, 2'b00);
      issue(0, 16'h0100, 0, 2'b00);
      issue(0, 16'h0100, 0, 2'b00);
      issue(0, 16'h0100, 0, 2'b11);
      // read immediately followed by writes (R8)
      for (int i = 0; i < 6; i++) begin
         issue(0, 16'(16'h0200 + i), 0, 2'b11);
         issue(1, 16'(16'h0200 + i), 16'(16'h7000 + 16'(i) * 16'h0111), 2'(i % 3 + 1));
         issue(0, 16'(16'h0200 + i), 0, 2'b11);
      end
      // random mix over a small window so addresses repeat
      for (int i = 0; i < 220; i++) begin
         logic [15:0] a;
         a = 16'(16'h0300 + ($urandom % 24));
         issue(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
      end
      drain();
      repeat (4) @(negedge clk);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule